// File: doc/BRIEF.md
# Local data RAM side port for DMA

This block gives an external DMA engine word, halfword or byte access to a core's local data RAM. The engine presents a byte address, a direction, an access size and write data. The block turns these into a word address and four byte-lane write enables, moves narrow write data onto the correct lanes, and hands read data back. Reads always return a full word.

A build-time parameter selects how the RAM is reached. With a single-ported RAM, the block sits between the core and the RAM's only port. The engine raises a wait input to ask for the core to be stalled. The block answers with a stall to the core and a ready to the engine one cycle later. While ready is high, the engine owns the port. At all other times the core's own signals pass through unchanged. With a dual-ported RAM, the engine drives the second port directly. The core keeps the first port and is never stalled, and the wait input has no effect.

Top module: `tcm_dma_port`

## Requirements
- R1: During a DMA access, the RAM word address equals the DMA byte address shifted right by two, so bits 25:2 of the byte address become the 24-bit word address.
- R2: Write enable bit k enables bits 8k+7:8k of the write data. A byte write (size 00) enables only the lane numbered by address bits 1:0. An aligned halfword write (size 01) enables lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1. A word write (size 10) enables all four lanes.
- R3: A byte write repeats data bits 7:0 on all four lanes. A halfword write repeats data bits 15:0 on both halves. A word write passes the data unchanged.
- R4: Size code 11 (reserved) and a halfword write with address bit 0 set both perform an access with no lane enabled.
- R5: The direction input selects a read when 0 and a write when 1. A read enables the RAM with no lane enabled, whatever the size, and the DMA read data equals the read data of the port in use.
- R6: No DMA access happens while the request input (active low) is high or the port enable is low.
- R7: In single-port mode, ready and the core stall rise on the clock edge after wait is seen high, and fall on the clock edge after wait is seen low. Both are low after reset.
- R8: In single-port mode, whenever ready is low, the RAM port carries the core's enable, address, write enables and write data unchanged. The DMA inputs then have no effect on the port.
- R9: In dual-port mode, DMA accesses use only the second port and need no ready. The first port always carries the core's signals. Ready and the core stall stay low even with wait high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_req_n | input | 1 | DMA request, active low |
| dma_en | input | 1 | DMA port enable |
| dma_wr | input | 1 | Direction: 0 read, 1 write |
| dma_size | input | 2 | Write size: 00 byte, 01 halfword, 10 word, 11 reserved |
| dma_addr | input | 26 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_wait | input | 1 | Request to stall the core (single-port mode) |
| dma_ready | output | 1 | Core is stalled and the engine owns the RAM |
| dma_rdata | output | 32 | Read data returned to the engine |
| core_en | input | 1 | Core RAM enable |
| core_addr | input | 24 | Core RAM word address |
| core_we | input | 4 | Core byte write enables |
| core_wdata | input | 32 | Core write data |
| core_stall | output | 1 | Stall to the core |
| ram_en | output | 1 | RAM port 1 enable |
| ram_addr | output | 24 | RAM port 1 word address |
| ram_we | output | 4 | RAM port 1 byte write enables |
| ram_wdata | output | 32 | RAM port 1 write data |
| ram_rdata | input | 32 | RAM port 1 read data |
| ram2_en | output | 1 | RAM port 2 enable |
| ram2_addr | output | 24 | RAM port 2 word address |
| ram2_we | output | 4 | RAM port 2 byte write enables |
| ram2_wdata | output | 32 | RAM port 2 write data |
| ram2_rdata | input | 32 | RAM port 2 read data |

## Verification
The bench runs every pairing of direction, size code and low address bits through a single-port and a dual-port instance side by side, and computes the expected lane enables, lane data and word address arithmetically. A design with the lane order reversed, or one that repeats data wrongly, writes the wrong bytes. A design that lets the reserved size or an odd halfword through corrupts neighbouring bytes. A read that enables lanes overwrites the RAM. The bench also drives DMA inputs while ready is low and requires the core's signals on the port unchanged. A design that let the engine in early would corrupt core accesses. It then checks the one-cycle rise and fall of ready, and that the dual-port build never stalls. A wrong build here would either stall the core needlessly or fail to hand the port back.

// File: rtl/tcm_dma_port.sv
module tcm_dma_port #(
  parameter bit DUAL_PORT = 1'b0,
  parameter int BYTE_AW   = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_req_n,
  input  logic               dma_en,
  input  logic               dma_wr,
  input  logic [1:0]         dma_size,
  input  logic [BYTE_AW-1:0] dma_addr,
  input  logic [31:0]        dma_wdata,
  input  logic               dma_wait,
  output logic               dma_ready,
  output logic [31:0]        dma_rdata,
  input  logic               core_en,
  input  logic [BYTE_AW-3:0] core_addr,
  input  logic [3:0]         core_we,
  input  logic [31:0]        core_wdata,
  output logic               core_stall,
  output logic               ram_en,
  output logic [BYTE_AW-3:0] ram_addr,
  output logic [3:0]         ram_we,
  output logic [31:0]        ram_wdata,
  input  logic [31:0]        ram_rdata,
  output logic               ram2_en,
  output logic [BYTE_AW-3:0] ram2_addr,
  output logic [3:0]         ram2_we,
  output logic [31:0]        ram2_wdata,
  input  logic [31:0]        ram2_rdata
);
  localparam int WORD_AW = BYTE_AW - 2;

  logic               stall_q;
  logic               go;
  logic               own;
  logic [1:0]         lo;
  logic [3:0]         lanes;
  logic [3:0]         be;
  logic [31:0]        wd;
  logic [WORD_AW-1:0] waddr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= dma_wait && !DUAL_PORT;

  assign dma_ready  = stall_q;
  assign core_stall = stall_q;
  assign own        = !DUAL_PORT && stall_q;
  assign go         = !dma_req_n && dma_en && (DUAL_PORT || stall_q);
  assign lo         = dma_addr[1:0];
  assign waddr      = dma_addr[BYTE_AW-1:2];

  always_comb begin
    case (dma_size)
      2'b00: begin lanes = 4'b0001 << lo; wd = {4{dma_wdata[7:0]}}; end
      2'b01: begin
        lanes = lo[0] ? 4'b0000 : (lo[1] ? 4'b1100 : 4'b0011);
        wd    = {2{dma_wdata[15:0]}};
      end
      2'b10:   begin lanes = 4'b1111; wd = dma_wdata; end
      default: begin lanes = 4'b0000; wd = dma_wdata; end
    endcase
    be = (go && dma_wr) ? lanes : 4'b0000;
  end

  assign ram_en     = own ? go    : core_en;
  assign ram_addr   = own ? waddr : core_addr;
  assign ram_we     = own ? be    : core_we;
  assign ram_wdata  = own ? wd    : core_wdata;

  assign ram2_en    = DUAL_PORT && go;
  assign ram2_addr  = DUAL_PORT ? waddr : '0;
  assign ram2_we    = DUAL_PORT ? be    : 4'b0000;
  assign ram2_wdata = DUAL_PORT ? wd    : '0;

  assign dma_rdata  = DUAL_PORT ? ram2_rdata : ram_rdata;

  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wait && !DUAL_PORT) |=> dma_ready);
  p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_wait |=> !dma_ready);
  p_core_owns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ready |-> (ram_en == core_en && ram_addr == core_addr &&
                    ram_we == core_we && ram_wdata == core_wdata));
  p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_size == 2'b11 || (dma_size == 2'b01 && dma_addr[0])) |->
      (ram2_we == 4'b0000 && (!dma_ready || ram_we == 4'b0000)));
  p_read_nowe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_wr |-> (ram2_we == 4'b0000 && (!dma_ready || ram_we == 4'b0000)));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_n || !dma_en) |-> (!ram2_en && (!dma_ready || !ram_en)));
  p_nostall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    DUAL_PORT |-> (!core_stall && !dma_ready));
endmodule

// File: tb/test_tcm_dma_port.sv
module test_tcm_dma_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_n, en, wr, wt, c_en;
  logic [1:0]  size;
  logic [25:0] addr;
  logic [31:0] wdata, c_wdata, rd1, rd2;
  logic [23:0] c_addr;
  logic [3:0]  c_we;

  logic        s_ready, s_stall, s_en, s_en2;
  logic [31:0] s_rdata, s_wd, s_wd2;
  logic [23:0] s_ad, s_ad2;
  logic [3:0]  s_we, s_we2;
  logic        d_ready, d_stall, d_en, d_en2;
  logic [31:0] d_rdata, d_wd, d_wd2;
  logic [23:0] d_ad, d_ad2;
  logic [3:0]  d_we, d_we2;

  int runs = 0, fails = 0;
  bit done = 1'b0;

  tcm_dma_port i_tcm_dma_port (
    .clk(clk), .rst_n(rst_n), .dma_req_n(req_n), .dma_en(en), .dma_wr(wr),
    .dma_size(size), .dma_addr(addr), .dma_wdata(wdata), .dma_wait(wt),
    .dma_ready(s_ready), .dma_rdata(s_rdata), .core_en(c_en), .core_addr(c_addr),
    .core_we(c_we), .core_wdata(c_wdata), .core_stall(s_stall), .ram_en(s_en),
    .ram_addr(s_ad), .ram_we(s_we), .ram_wdata(s_wd), .ram_rdata(rd1),
    .ram2_en(s_en2), .ram2_addr(s_ad2), .ram2_we(s_we2), .ram2_wdata(s_wd2),
    .ram2_rdata(rd2));

  tcm_dma_port #(.DUAL_PORT(1'b1)) i_tcm_dma_port_dp (
    .clk(clk), .rst_n(rst_n), .dma_req_n(req_n), .dma_en(en), .dma_wr(wr),
    .dma_size(size), .dma_addr(addr), .dma_wdata(wdata), .dma_wait(wt),
    .dma_ready(d_ready), .dma_rdata(d_rdata), .core_en(c_en), .core_addr(c_addr),
    .core_we(c_we), .core_wdata(c_wdata), .core_stall(d_stall), .ram_en(d_en),
    .ram_addr(d_ad), .ram_we(d_we), .ram_wdata(d_wd), .ram_rdata(rd1),
    .ram2_en(d_en2), .ram2_addr(d_ad2), .ram2_we(d_we2), .ram2_wdata(d_wd2),
    .ram2_rdata(rd2));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic core_pass(input string tag);
    chk(s_en == c_en && s_we == c_we && s_ad == c_addr && s_wd == c_wdata,
        tag, {s_we, s_ad}, {c_we, c_addr});
  endtask

  function automatic logic [3:0] exp_we(input logic w, input logic [1:0] sz,
                                        input logic [1:0] a);
    if (!w) return 4'b0000;
    case (sz)
      2'b00:   return 4'(1 << a);
      2'b01:   return a[0] ? 4'b0000 : (a[1] ? 4'b1100 : 4'b0011);
      2'b10:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {4{d[7:0]}};
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_n = 1'b1; en = 1'b0; wr = 1'b0; wt = 1'b0; size = 2'b10;
    addr = '0; wdata = '0; c_en = 1'b1; c_addr = 24'h12_3456; c_we = 4'b0101;
    c_wdata = 32'hCAFE_F00D; rd1 = 32'h1111_2222; rd2 = 32'h3333_4444;
    repeat (3) @(negedge clk);
    #1;
    chk(!s_ready && !s_stall, "R7 reset ready", {s_ready, s_stall}, 0);
    core_pass("R8 reset passthrough");
    rst_n = 1'b1;
    @(negedge clk);
    req_n = 1'b0; en = 1'b1; wr = 1'b1; size = 2'b10; addr = 26'h3FF_FFFC;
    wdata = 32'hDEAD_BEEF;
    #1;
    core_pass("R8 dma ignored while not ready");
    chk(!s_ready, "R8 ready low", s_ready, 0);
    wt = 1'b1;
    #1;
    chk(!s_ready, "R7 ready waits for edge", s_ready, 0);
    @(negedge clk); #1;
    chk(s_ready && s_stall, "R7 ready rises", {s_ready, s_stall}, 2'b11);
    chk(!d_ready && !d_stall, "R9 dual never stalls", {d_ready, d_stall}, 0);
    chk(d_en == c_en && d_we == c_we && d_ad == c_addr && d_wd == c_wdata,
        "R9 port1 core in dual", {d_we, d_ad}, {c_we, c_addr});

    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 4; a++) begin
          logic [3:0] ew;
          logic [23:0] ea;
          wr = w[0]; size = sz[1:0];
          addr = {24'hA5_C3F0 + 24'(sz * 4 + a), a[1:0]};
          wdata = 32'h8765_4321 ^ (32'(a) << 8) ^ 32'(sz);
          rd1 = 32'h0BAD_0000 | 32'(a); rd2 = 32'h0D0E_0000 | 32'(sz);
          ew = exp_we(w[0], sz[1:0], a[1:0]);
          ea = addr[25:2];
          #1;
          chk(s_en && s_ad == ea, "R1 single addr", s_ad, ea);
          chk(d_en2 && d_ad2 == ea, "R1 dual addr", d_ad2, ea);
          chk(s_we == ew, (sz == 3 || (sz == 1 && a[0])) ? "R4 single lanes" :
              (w == 0 ? "R5 single read lanes" : "R2 single lanes"), s_we, ew);
          chk(d_we2 == ew, (sz == 3 || (sz == 1 && a[0])) ? "R4 dual lanes" :
              (w == 0 ? "R5 dual read lanes" : "R2 dual lanes"), d_we2, ew);
          if (ew != 0) begin
            chk(s_wd == exp_wd(sz[1:0], wdata), "R3 single data", s_wd,
                exp_wd(sz[1:0], wdata));
            chk(d_wd2 == exp_wd(sz[1:0], wdata), "R3 dual data", d_wd2,
                exp_wd(sz[1:0], wdata));
          end
          if (w == 0) begin
            chk(s_rdata == rd1, "R5 single rdata", s_rdata, rd1);
            chk(d_rdata == rd2, "R5 dual rdata", d_rdata, rd2);
          end
          chk(d_en == c_en && d_we == c_we, "R9 dual port1", {d_en, d_we}, {c_en, c_we});
          @(negedge clk);
        end

    wr = 1'b1; size = 2'b10; req_n = 1'b1; #1;
    chk(!s_en && s_we == 0, "R6 req high single", {s_en, s_we}, 0);
    chk(!d_en2 && d_we2 == 0, "R6 req high dual", {d_en2, d_we2}, 0);
    req_n = 1'b0; en = 1'b0; #1;
    chk(!s_en && s_we == 0, "R6 enable low single", {s_en, s_we}, 0);
    chk(!d_en2 && d_we2 == 0, "R6 enable low dual", {d_en2, d_we2}, 0);
    en = 1'b1;
    @(negedge clk);
    wt = 1'b0; #1;
    chk(s_ready, "R7 ready holds until edge", s_ready, 1);
    @(negedge clk); #1;
    chk(!s_ready && !s_stall, "R7 ready falls", {s_ready, s_stall}, 0);
    c_we = 4'b1000; c_addr = 24'h00_0007; c_wdata = 32'h0102_0304; #1;
    core_pass("R8 core back after release");
    wt = 1'b1; @(negedge clk); #1;
    chk(!d_ready && !d_stall, "R9 dual stays unstalled", {d_ready, d_stall}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule